// File: doc/BRIEF.md
# Progressive Frame Accumulation Averager

This block sits on the merged pixel stream, after the depth-composition tree and ahead of the color lookup tables. Its job is to refine an image that is not moving. When a frame follows a scene change, each pixel goes out unchanged and is also saved to an external accumulation memory. Each later frame in a still run mixes the new sample with the saved value and writes the mixed value back. The weights of that mix depend on how many frames have been accumulated so far.

A frame counter k starts at zero on the frame that follows motion and counts up by one on every still frame. It stops at 2^M-1. In frame k the new sample has weight 1/(k+1) and the stored pixel has weight k/(k+1). The still flag is looked at only on the first pixel of a frame, so every pixel of one frame uses the same weight.

For each input pixel the block issues the memory read in the same cycle the pixel arrives. The returned word is mixed one cycle later, and the result goes out and is written back one cycle after that. This sustains one pixel per clock. The memory must have a one-cycle registered read.

Top module: `accum_avg`

## Requirements
- R1: In reset and on the first edge after it, out_valid, wr_en and rd_en are all 0.
- R2: In a pass-through frame every output pixel equals the input pixel and is written back unchanged. A pass-through frame is the first frame after reset, or any frame whose first pixel sees in_still at 0.
- R3: A pixel presented on clock edge n appears on out_rgb with out_valid high after edge n+1. Its out_sof equals its in_sof. Back-to-back pixels flow at one per clock.
- R4: rd_en equals in_valid. rd_addr is 0 on a first pixel (in_sof=1). For later pixels rd_addr is one more than the address of the previous valid pixel, and idle cycles do not advance it.
- R5: When k>=1, each 8-bit channel is computed as (n*Wn + s*(65536-Wn) + 32768) >> 16, with Wn = floor((65536 + floor((k+1)/2)) / (k+1)). Here n is the new sample and s is the stored value.
- R6: k increases by one on each still frame and holds at 2^M-1 (15 by default).
- R7: in_still is ignored on every pixel except the first pixel of a frame. A change in the middle of a frame does not alter that frame's weights.
- R8: A first pixel with in_still at 0 restarts accumulation at k=0, whatever k was before.
- R9: With each output, wr_en is 1, wr_addr is the rd_addr issued for that pixel, and wr_data equals out_rgb.
- R10: Channels are packed with channel c at bits [c*8 +: 8] and are blended independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_still | input | 1 | Scene stationary; sampled on the first pixel |
| in_rgb | input | PW | Merged pixel color, NCH channels of CH_W bits |
| rd_en | output | 1 | Accumulation memory read strobe |
| rd_addr | output | AW | Accumulation memory read address |
| rd_data | input | PW | Read word, valid one cycle after rd_en |
| wr_en | output | 1 | Accumulation memory write strobe |
| wr_addr | output | AW | Accumulation memory write address |
| wr_data | output | PW | Word written back |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_rgb | output | PW | Averaged pixel toward the lookup tables |

## Verification
Two things coincide in the same cycle: the write-back of a frame's closing pixels and the read for the next frame's opening pixel, which also takes the new k. To provoke this, frames of four pixels are sent back to back with no idle gap, so the new start-of-frame read lands while the previous writes are still in flight. The result is judged against a bench model that keeps its own copy of the accumulated image and its own k. Every output pixel is compared with that model for value, address, framing and cycle of arrival.

// File: rtl/accum_pkg.sv
package accum_pkg;
   // fixed-point precision of the blend weights
   localparam int FRAC_W = 16;

   // weight of the new sample in frame k: round(2^FRAC_W / (k+1))
   function automatic logic [FRAC_W:0] new_weight(input int unsigned k);
      int unsigned one;
      one = 32'd1 << FRAC_W;
      return (FRAC_W+1)'((one + (k + 1) / 2) / (k + 1));
   endfunction
endpackage

// File: rtl/accum_frame_ctl.sv
module accum_frame_ctl #(
   parameter int M  = 4,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic          in_still,
   output logic [AW-1:0] pix_addr,
   output logic [M-1:0]  pix_k
);
   localparam logic [M-1:0] KMAX = {M{1'b1}};

   logic [M-1:0]  k_q;
   logic          primed_q;
   logic [AW-1:0] cnt_q;
   logic [M-1:0]  k_sof;

   always_comb begin
      if (!in_still || !primed_q)
         k_sof = '0;
      else if (k_q == KMAX)
         k_sof = KMAX;
      else
         k_sof = k_q + 1'b1;
      pix_k    = in_sof ? k_sof : k_q;
      pix_addr = in_sof ? '0 : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q      <= '0;
         primed_q <= 1'b0;
         cnt_q    <= '0;
      end else if (in_valid) begin
         cnt_q <= pix_addr + 1'b1;
         if (in_sof) begin
            k_q      <= k_sof;
            primed_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/accum_blend.sv
module accum_blend
   import accum_pkg::*;
#(
   parameter int CH_W = 8,
   parameter int NCH  = 3,
   parameter int M    = 4,
   parameter int PW   = CH_W * NCH
) (
   input  logic [M-1:0]  k,
   input  logic [PW-1:0] new_px,
   input  logic [PW-1:0] old_px,
   output logic [PW-1:0] mix_px
);
   localparam int KN = 1 << M;
   localparam int WW = FRAC_W + 1;
   localparam int SW = CH_W + FRAC_W + 1;

   logic [WW-1:0] wn_tab [KN];
   logic [WW-1:0] wn;
   logic [WW-1:0] wo;

   for (genvar gk = 0; gk < KN; gk++) begin : g_wtab
      assign wn_tab[gk] = new_weight(gk);
   end

   assign wn = wn_tab[k];
   assign wo = WW'(1 << FRAC_W) - wn;

   for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
      logic [SW-1:0] acc;
      assign acc = SW'(new_px[gc*CH_W +: CH_W]) * SW'(wn)
                 + SW'(old_px[gc*CH_W +: CH_W]) * SW'(wo)
                 + SW'(1 << (FRAC_W - 1));
      assign mix_px[gc*CH_W +: CH_W] = (k == '0) ? new_px[gc*CH_W +: CH_W]
                                                 : acc[FRAC_W +: CH_W];
   end
endmodule

// File: rtl/accum_avg.sv
module accum_avg #(
   parameter int CH_W = 8,
   parameter int NCH  = 3,
   parameter int M    = 4,
   parameter int AW   = 12,
   localparam int PW  = CH_W * NCH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic          in_still,
   input  logic [PW-1:0] in_rgb,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [PW-1:0] rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [PW-1:0] wr_data,
   output logic          out_valid,
   output logic          out_sof,
   output logic [PW-1:0] out_rgb
);
   if (M < 1 || M > 8) begin : g_bad_m
      $error("accum_avg: M must lie in 1..8");
   end
   if (CH_W < 1 || CH_W > 16) begin : g_bad_w
      $error("accum_avg: CH_W must lie in 1..16");
   end
   if (AW < 2) begin : g_bad_aw
      $error("accum_avg: AW must be at least 2");
   end

   logic [AW-1:0] pix_addr;
   logic [M-1:0]  pix_k;

   accum_frame_ctl #(.M(M), .AW(AW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sof   (in_sof),
      .in_still (in_still),
      .pix_addr (pix_addr),
      .pix_k    (pix_k)
   );

   assign rd_en   = in_valid;
   assign rd_addr = pix_addr;

   // stage 1: wait for the memory word
   logic          s1_valid;
   logic          s1_sof;
   logic [PW-1:0] s1_px;
   logic [AW-1:0] s1_addr;
   logic [M-1:0]  s1_k;
   logic [PW-1:0] mix_px;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_px    <= '0;
         s1_addr  <= '0;
         s1_k     <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sof  <= in_sof;
            s1_px   <= in_rgb;
            s1_addr <= pix_addr;
            s1_k    <= pix_k;
         end
      end
   end

   accum_blend #(.CH_W(CH_W), .NCH(NCH), .M(M), .PW(PW)) u_blend (
      .k      (s1_k),
      .new_px (s1_px),
      .old_px (rd_data),
      .mix_px (mix_px)
   );

   // stage 2: output and write-back
   logic [PW-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         res_q     <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
      end else begin
         out_valid <= s1_valid;
         wr_en     <= s1_valid;
         if (s1_valid) begin
            out_sof <= s1_sof;
            res_q   <= mix_px;
            wr_addr <= s1_addr;
         end
      end
   end

   assign out_rgb = res_q;
   assign wr_data = res_q;
endmodule

// File: rtl/accum_avg_chk.sv
module accum_avg_chk #(
   parameter int CH_W = 8,
   parameter int NCH  = 3,
   parameter int AW   = 12,
   parameter int PW   = CH_W * NCH
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_sof,
   input logic          in_still,
   input logic [PW-1:0] in_rgb,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          out_valid,
   input logic          out_sof,
   input logic [PW-1:0] out_rgb
);
   logic [1:0]    cyc;
   logic          primed_c;
   logic          pass_fr_c;
   logic          pass_now;
   logic          pass_d1;
   logic          pass_d2;
   logic [AW-1:0] nxt_c;

   assign pass_now = in_sof ? (!in_still || !primed_c) : pass_fr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc       <= '0;
         primed_c  <= 1'b0;
         pass_fr_c <= 1'b1;
         pass_d1   <= 1'b0;
         pass_d2   <= 1'b0;
         nxt_c     <= '0;
      end else begin
         if (cyc != 2'd3) cyc <= cyc + 1'b1;
         pass_d1 <= in_valid && pass_now;
         pass_d2 <= pass_d1;
         if (in_valid) begin
            nxt_c <= (in_sof ? '0 : nxt_c) + 1'b1;
            if (in_sof) begin
               pass_fr_c <= pass_now;
               primed_c  <= 1'b1;
            end
         end
      end
   end

   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   a_r3_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && out_valid) |-> (out_sof == $past(in_sof, 2)));

   a_r4_sof_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |-> (rd_en && rd_addr == '0));

   a_r4_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sof) |-> (rd_addr == nxt_c));

   a_r9_wb_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && wr_en) |-> (wr_addr == $past(rd_addr, 2)));

   a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && out_valid && pass_d2) |-> (out_rgb == $past(in_rgb, 2)));
endmodule

bind accum_avg accum_avg_chk #(.CH_W(CH_W), .NCH(NCH), .AW(AW), .PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .in_still  (in_still),
   .in_rgb    (in_rgb),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_rgb   (out_rgb)
);

// File: tb/accum_avg_test.sv
`timescale 1ns/1ps
module accum_avg_test;
   localparam int CH_W  = 8;
   localparam int NCH   = 3;
   localparam int M     = 4;
   localparam int AW    = 4;
   localparam int PW    = CH_W * NCH;
   localparam int FRAME = 4;
   localparam int KMAX  = (1 << M) - 1;
   localparam int NEXP  = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sof = 1'b0;
   logic          in_still = 1'b0;
   logic [PW-1:0] in_rgb = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [PW-1:0] rd_q;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [PW-1:0] wr_data;
   logic          out_valid;
   logic          out_sof;
   logic [PW-1:0] out_rgb;

   always #10 clk = ~clk;

   accum_avg #(.CH_W(CH_W), .NCH(NCH), .M(M), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_still(in_still), .in_rgb(in_rgb), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_valid(out_valid), .out_sof(out_sof), .out_rgb(out_rgb));

   // external accumulation memory, one-cycle registered read
   logic [PW-1:0] mem [1 << AW];
   always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   int checks = 0;
   int errors = 0;
   int cc = 0;
   always_ff @(posedge clk) cc <= cc + 1;

   // bench model
   logic [PW-1:0] acc_m [1 << AW];
   int            mk = 0;
   bit            mprimed = 0;
   int            m_addr = 0;
   logic [PW-1:0] exp_rgb  [NEXP];
   int            exp_addr [NEXP];
   bit            exp_sof  [NEXP];
   bit            exp_pass [NEXP];
   int            exp_cyc  [NEXP];
   int            n_in = 0;
   int            n_out = 0;

   function automatic logic [PW-1:0] model_mix(input logic [PW-1:0] n,
                                               input logic [PW-1:0] s, input int k);
      logic [PW-1:0] r;
      longint wn, wo, v;
      wn = (65536 + (k + 1) / 2) / (k + 1);
      wo = 65536 - wn;
      for (int c = 0; c < NCH; c++) begin
         v = (longint'(n[c*CH_W +: CH_W]) * wn + longint'(s[c*CH_W +: CH_W]) * wo
              + 32768) >> 16;
         r[c*CH_W +: CH_W] = CH_W'(v);
      end
      return (k == 0) ? n : r;
   endfunction

   function automatic logic [PW-1:0] pix_of(input int seed, input int p);
      logic [PW-1:0] r;
      for (int c = 0; c < NCH; c++) begin
         if (seed == 0)        r[c*CH_W +: CH_W] = 8'h00;
         else if (seed == 255) r[c*CH_W +: CH_W] = 8'hFF;
         else r[c*CH_W +: CH_W] = CH_W'(seed + p * 53 + c * 91);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // drive one pixel; still is sampled by the model only on sof (R7)
   task automatic send(input bit sof, input bit still, input logic [PW-1:0] px);
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_still = still; in_rgb = px;
      if (sof) begin
         if (!still || !mprimed) mk = 0;
         else if (mk < KMAX) mk++;
         mprimed = 1;
         m_addr = 0;
      end
      exp_rgb[n_in]  = model_mix(px, acc_m[m_addr], mk);
      exp_pass[n_in] = (mk == 0);
      exp_addr[n_in] = m_addr;
      exp_sof[n_in]  = sof;
      exp_cyc[n_in]  = cc + 2;
      acc_m[m_addr]  = exp_rgb[n_in];
      #1;
      check(rd_en == 1'b1 && int'(rd_addr) == m_addr, "R4 read address",
            longint'(rd_addr), longint'(m_addr));
      m_addr++;
      n_in++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b0;
      end
   endtask

   task automatic frame(input bit still, input int seed);
      for (int p = 0; p < FRAME; p++) send(p == 0, still, pix_of(seed, p));
   endtask

   // output monitor: R2, R3, R5, R9, R10
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (n_out >= n_in) begin
            check(1'b0, "R3 spurious output", 1, 0);
         end else begin
            check(out_rgb == exp_rgb[n_out],
                  exp_pass[n_out] ? "R2 pass-through value" : "R5 R10 blended value",
                  longint'(out_rgb), longint'(exp_rgb[n_out]));
            check(cc == exp_cyc[n_out], "R3 output cycle",
                  longint'(cc), longint'(exp_cyc[n_out]));
            check(out_sof == exp_sof[n_out], "R3 out_sof",
                  longint'(out_sof), longint'(exp_sof[n_out]));
            check(wr_en && int'(wr_addr) == exp_addr[n_out] && wr_data == out_rgb,
                  "R9 write-back", longint'(wr_addr), longint'(exp_addr[n_out]));
         end
         n_out++;
      end
   end

   // stimulus table: {still, seed}
   localparam logic [8:0] VEC [10] = '{
      {1'b1, 8'h10}, {1'b1, 8'h20}, {1'b1, 8'h30}, {1'b1, 8'hFF},
      {1'b0, 8'h40}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b1, 8'h80},
      {1'b0, 8'h11}, {1'b1, 8'h22}};

   bit done = 0;

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, n_in);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R1 outputs in reset",
            longint'({out_valid, wr_en, rd_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R1 outputs after reset",
            longint'({out_valid, wr_en, rd_en}), 0);

      // table walk: R2 first frame after reset, R5 blends, R8 motion restart
      foreach (VEC[i]) frame(VEC[i][8], int'(VEC[i][7:0]));

      // R7: still dropped mid-frame does not change this frame's weight
      send(1'b1, 1'b1, pix_of(8'h55, 0));
      send(1'b0, 1'b0, pix_of(8'h55, 1));
      send(1'b0, 1'b0, pix_of(8'h55, 2));
      send(1'b0, 1'b1, pix_of(8'h55, 3));
      // R7/R8: still low at sof, raised mid-frame -> whole frame passes through
      send(1'b1, 1'b0, pix_of(8'h66, 0));
      send(1'b0, 1'b1, pix_of(8'h66, 1));
      send(1'b0, 1'b1, pix_of(8'h66, 2));
      send(1'b0, 1'b1, pix_of(8'h66, 3));

      // R4 with idle gaps inside a frame
      send(1'b1, 1'b1, pix_of(8'h77, 0));
      idle(2);
      send(1'b0, 1'b1, pix_of(8'h77, 1));
      idle(1);
      send(1'b0, 1'b1, pix_of(8'h77, 2));
      send(1'b0, 1'b1, pix_of(8'h77, 3));
      idle(3);

      // R6: long still run saturates k at 2^M-1
      for (int f = 0; f < KMAX + 6; f++) frame(1'b1, (f % 2 == 0) ? 255 : 0);
      // R8: motion after saturation restarts
      frame(1'b0, 8'h3C);
      frame(1'b1, 8'hC3);

      idle(6);
      check(n_out == n_in, "R3 all pixels delivered", longint'(n_out), longint'(n_in));
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule